// File: doc/BRIEF.md
# Video Fetch Address Generator

This block produces the byte address of every display memory fetch in a bitmapped video controller. A live refresh counter advances by one 16-bit word on every fetch strobe that falls inside the active fetch window. At the end of each active line it jumps forward by a programmable line offset, so that the visible window can sit inside a virtual screen wider than the display. At the start of every frame it reloads from a programmable frame base address.

The host reaches the block through a small byte-wide register port. It can place the frame base on any word boundary, and it can read or overwrite any byte of the live counter at any moment, so a display list can relocate the picture in the middle of a frame. A nonzero fine-scroll value makes the block skip one extra data fetch at every line end. The size of that data fetch is four words in the 4-plane mode and one word in the single-plane mode. Software compensates by lowering the line offset by the same amount. Vertical scrolling is done by rewriting the base during horizontal blanking.

Top module: `vfa_top`

## Requirements
- R1: While `rst` is high, the cycle after it is sampled shows `fetch_addr` = 0, and every register in the map reads 0.
- R2: The base address is written and read as three bytes: select 3 is bits 7:0, select 4 is bits 15:8 and select 5 is bits 21:16. Bit 0 always reads 0, and only the six low bits of select 5 are kept. The line offset (select 6, 8 bits) and the fine-scroll value (select 7, 4 bits, zero-extended on read) read back what was written.
- R3: A cycle with `frame_start` high loads the frame base, as it stood in that cycle, into `fetch_addr` on the next cycle.
- R4: A cycle with `fetch_stb` and `active` both high adds 2 to `fetch_addr`, counted in bytes. A fetch strobe with `active` low, or a cycle with no event at all, leaves `fetch_addr` unchanged.
- R5: A cycle with `line_end` high and fine scroll at zero adds twice the line offset to `fetch_addr`.
- R6: A cycle with `line_end` high and fine scroll nonzero adds 2 × (offset + F), where F is 4 when `plane4` = 1 and 1 when `plane4` = 0.
- R7: A host write to select 0, 1 or 2 replaces counter bits 7:0, 15:8 or 21:16 on the next cycle. Bit 0 is forced to 0. The same selects read the live counter.
- R8: A host counter write in the same cycle as a frame start, line end or fetch strobe wins: only the byte replacement takes effect in that cycle.
- R9: Without a host counter write, a frame start overrides a line end, and a line end overrides a fetch strobe in the same cycle.
- R10: With the line offset and fine scroll both at zero, a line end leaves `fetch_addr` unchanged.
- R11: The counter wraps modulo 2^22, so a fetch from 0x3FFFFE gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe for the selected register |
| reg_sel | input | 3 | Register select (0-2 counter, 3-5 base, 6 offset, 7 scroll) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| plane4 | input | 1 | 1: 4-plane mode, data fetch of 4 words; 0: 1 word |
| active | input | 1 | Active fetch window; fetch strobes outside it are ignored |
| fetch_stb | input | 1 | One word fetched |
| line_end | input | 1 | End of the active line |
| frame_start | input | 1 | Start of frame (vertical sync) |
| fetch_addr | output | 22 | Current fetch byte address (always even) |

## Verification
The conflict that matters most is a host rewrite of a counter byte that lands in the same cycle as the line-end jump. The jump is also raced against a frame reload and against a fetch strobe. Directed cycles raise the colliding strobes together: a middle-byte write with `line_end`, a low-byte write with `frame_start`, and a frame start with a line end. The random phase then lets host writes and timing strobes collide often. After each such cycle, the counter is compared with the value that only the winning event would produce. A wrong priority shows up at once as an offset jump or a reload where a byte replacement was expected.

// File: rtl/vfa_pkg.sv
package vfa_pkg;

    localparam int unsigned ADDR_W    = 22;
    localparam int unsigned OFS_W     = 8;
    localparam int unsigned SCROLL_W  = 4;
    localparam int unsigned WIDE_FETCH   = 4;  // words per data fetch, 4-plane
    localparam int unsigned NARROW_FETCH = 1;  // words per data fetch, 1-plane

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [OFS_W-1:0]    ofs_t;
    typedef logic [SCROLL_W-1:0] scroll_t;

    localparam logic [2:0] SEL_CTR_LO  = 3'd0;
    localparam logic [2:0] SEL_CTR_MID = 3'd1;
    localparam logic [2:0] SEL_CTR_HI  = 3'd2;
    localparam logic [2:0] SEL_BAS_LO  = 3'd3;
    localparam logic [2:0] SEL_BAS_MID = 3'd4;
    localparam logic [2:0] SEL_BAS_HI  = 3'd5;
    localparam logic [2:0] SEL_OFS     = 3'd6;
    localparam logic [2:0] SEL_SCROLL  = 3'd7;

    localparam addr_t WORD_MASK = ~addr_t'(1);

    typedef enum logic [2:0] {
        EV_HOLD,
        EV_FETCH,
        EV_LINE,
        EV_FRAME,
        EV_HOST
    } ev_e;

    typedef struct packed {
        logic [1:0] idx;
        logic [7:0] data;
    } byte_wr_t;

    function automatic addr_t put_byte(addr_t v, logic [1:0] idx, logic [7:0] d);
        addr_t mask;
        mask = addr_t'(8'hFF) << {idx, 3'b000};
        return ((v & ~mask) | (addr_t'(d) << {idx, 3'b000})) & WORD_MASK;
    endfunction

    function automatic logic [7:0] get_byte(addr_t v, logic [1:0] idx);
        addr_t t;
        t = v >> {idx, 3'b000};
        return t[7:0];
    endfunction

    function automatic addr_t line_jump(ofs_t ofs, logic scroll_nz, logic wide);
        addr_t words;
        words = addr_t'(ofs);
        if (scroll_nz)
            words = words + (wide ? addr_t'(WIDE_FETCH) : addr_t'(NARROW_FETCH));
        return words << 1;
    endfunction

endpackage

// File: rtl/vfa_regs.sv
module vfa_regs
    import vfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] sel,
    input  logic [7:0] wdata,
    input  addr_t      ctr,
    output logic [7:0] rdata,
    output addr_t      base_o,
    output ofs_t       ofs_o,
    output scroll_t    scroll_o
);

    addr_t   base_r;
    ofs_t    ofs_r;
    scroll_t scroll_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_r   <= '0;
            ofs_r    <= '0;
            scroll_r <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_BAS_LO:  base_r   <= put_byte(base_r, 2'd0, wdata);
                SEL_BAS_MID: base_r   <= put_byte(base_r, 2'd1, wdata);
                SEL_BAS_HI:  base_r   <= put_byte(base_r, 2'd2, wdata);
                SEL_OFS:     ofs_r    <= wdata[OFS_W-1:0];
                SEL_SCROLL:  scroll_r <= wdata[SCROLL_W-1:0];
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_CTR_LO:  rdata = get_byte(ctr, 2'd0);
            SEL_CTR_MID: rdata = get_byte(ctr, 2'd1);
            SEL_CTR_HI:  rdata = get_byte(ctr, 2'd2);
            SEL_BAS_LO:  rdata = get_byte(base_r, 2'd0);
            SEL_BAS_MID: rdata = get_byte(base_r, 2'd1);
            SEL_BAS_HI:  rdata = get_byte(base_r, 2'd2);
            SEL_OFS:     rdata = 8'(ofs_r);
            default:     rdata = 8'(scroll_r);
        endcase
    end

    assign base_o   = base_r;
    assign ofs_o    = ofs_r;
    assign scroll_o = scroll_r;

endmodule

// File: rtl/vfa_step.sv
module vfa_step
    import vfa_pkg::*;
(
    input  ev_e      ev,
    input  addr_t    cur,
    input  addr_t    base,
    input  byte_wr_t host,
    input  ofs_t     ofs,
    input  scroll_t  scroll,
    input  logic     wide,
    output addr_t    nxt
);

    always_comb begin
        unique case (ev)
            EV_HOST:  nxt = put_byte(cur, host.idx, host.data);
            EV_FRAME: nxt = base;
            EV_LINE:  nxt = cur + line_jump(ofs, scroll != '0, wide);
            EV_FETCH: nxt = cur + addr_t'(2);
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/vfa_top.sv
module vfa_top
    import vfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              plane4,
    input  logic              active,
    input  logic              fetch_stb,
    input  logic              line_end,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] fetch_addr
);

    addr_t    ctr_q;
    addr_t    ctr_d;
    addr_t    base_q;
    ofs_t     ofs_q;
    scroll_t  scroll_q;
    ev_e      ev;
    byte_wr_t host;
    logic     host_ctr;

    assign host_ctr = reg_wr && (reg_sel == SEL_CTR_LO || reg_sel == SEL_CTR_MID ||
                                 reg_sel == SEL_CTR_HI);

    always_comb begin
        host.idx  = reg_sel[1:0];
        host.data = reg_wdata;
    end

    // event priority: host counter write, frame reload, line jump, fetch step
    always_comb begin
        if (host_ctr)                 ev = EV_HOST;
        else if (frame_start)         ev = EV_FRAME;
        else if (line_end)            ev = EV_LINE;
        else if (fetch_stb && active) ev = EV_FETCH;
        else                          ev = EV_HOLD;
    end

    vfa_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .ctr      (ctr_q),
        .rdata    (reg_rdata),
        .base_o   (base_q),
        .ofs_o    (ofs_q),
        .scroll_o (scroll_q)
    );

    vfa_step u_step (
        .ev     (ev),
        .cur    (ctr_q),
        .base   (base_q),
        .host   (host),
        .ofs    (ofs_q),
        .scroll (scroll_q),
        .wide   (plane4),
        .nxt    (ctr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end

    assign fetch_addr = ctr_q;

endmodule

// File: rtl/vfa_chk.sv
module vfa_chk
    import vfa_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [2:0] reg_sel,
    input logic [7:0] reg_wdata,
    input logic       active,
    input logic       fetch_stb,
    input logic       line_end,
    input logic       frame_start,
    input addr_t      fetch_addr,
    input addr_t      base
);

    logic host_hit;
    assign host_hit = reg_wr && (reg_sel <= SEL_CTR_HI);

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> fetch_addr == '0);

    // R7
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_addr[0] == 1'b0);

    // R3
    frame_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !host_hit) |=> fetch_addr == $past(base));

    // R4
    fetch_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && fetch_stb && !line_end && !frame_start && !host_hit)
        |=> fetch_addr == addr_t'($past(fetch_addr) + addr_t'(2)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!host_hit && !frame_start && !line_end && !(active && fetch_stb))
        |=> $stable(fetch_addr));

    // R8
    host_low_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_CTR_LO) |=> fetch_addr[7:0] == ($past(reg_wdata) & 8'hFE));

    // R8
    host_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_CTR_MID) |=> fetch_addr[15:8] == $past(reg_wdata));

endmodule

bind vfa_top vfa_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr      (reg_wr),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .active      (active),
    .fetch_stb   (fetch_stb),
    .line_end    (line_end),
    .frame_start (frame_start),
    .fetch_addr  (fetch_addr),
    .base        (base_q)
);

// File: tb/tb_vfa_top.sv
`timescale 1ns/1ps
module tb_vfa_top;

    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_wr;
    logic [2:0]    reg_sel;
    logic [7:0]    reg_wdata;
    logic [7:0]    reg_rdata;
    logic          plane4;
    logic          active;
    logic          fetch_stb;
    logic          line_end;
    logic          frame_start;
    logic [AW-1:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench-side model of the programmable state
    logic [AW-1:0] m_ctr;
    logic [AW-1:0] m_base;
    logic [7:0]    m_ofs;
    logic [3:0]    m_scr;

    always #2.5 clk = ~clk;

    vfa_top dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .plane4(plane4),
        .active(active), .fetch_stb(fetch_stb), .line_end(line_end),
        .frame_start(frame_start), .fetch_addr(fetch_addr)
    );

    function automatic logic [AW-1:0] with_byte(logic [AW-1:0] v, int k, logic [7:0] d);
        logic [23:0] w;
        w = {{(24-AW){1'b0}}, v};
        w[k*8 +: 8] = d;
        w[0] = 1'b0;
        return w[AW-1:0];
    endfunction

    function automatic logic [7:0] byte_of(logic [AW-1:0] v, int k);
        logic [23:0] w;
        w = {{(24-AW){1'b0}}, v};
        return w[k*8 +: 8];
    endfunction

    function automatic logic [AW-1:0] expect_next(logic wr, logic [2:0] sel, logic [7:0] wd,
                                                  logic act, logic fs, logic le, logic fr,
                                                  logic p4);
        int words;
        if (wr && sel <= 3'd2) return with_byte(m_ctr, int'(sel), wd);
        if (fr) return m_base;
        if (le) begin
            words = int'(m_ofs);
            if (m_scr != 4'd0) words += (p4 ? 4 : 1);
            return m_ctr + AW'(2 * words);
        end
        if (fs && act) return m_ctr + AW'(2);
        return m_ctr;
    endfunction

    function automatic string tag_of(logic wr, logic [2:0] sel, logic act, logic fs,
                                     logic le, logic fr);
        logic host;
        host = wr && sel <= 3'd2;
        if (host && (fr || le || (fs && act))) return "R8";
        if (host) return "R7";
        if (fr && le) return "R9";
        if (fr) return "R3";
        if (le && m_scr != 4'd0) return "R6";
        if (le && m_ofs == 8'd0) return "R10";
        if (le) return "R5";
        return "R4";
    endfunction

    task automatic check(string tag, logic [31:0] act_v, logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic cyc(logic wr, logic [2:0] sel, logic [7:0] wd, logic act, logic fs,
                       logic le, logic fr, logic p4);
        logic [AW-1:0] e;
        string t;
        e = expect_next(wr, sel, wd, act, fs, le, fr, p4);
        t = tag_of(wr, sel, act, fs, le, fr);
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; active = act;
        fetch_stb = fs; line_end = le; frame_start = fr; plane4 = p4;
        @(posedge clk); #1;
        if (wr) begin
            case (sel)
                3'd3: m_base = with_byte(m_base, 0, wd);
                3'd4: m_base = with_byte(m_base, 1, wd);
                3'd5: m_base = with_byte(m_base, 2, wd & 8'h3F);
                3'd6: m_ofs  = wd;
                3'd7: m_scr  = wd[3:0];
                default: ;
            endcase
        end
        m_ctr = e;
        check(t, 32'(fetch_addr), 32'(e));
        reg_wr = 0; fetch_stb = 0; line_end = 0; frame_start = 0;
    endtask

    task automatic wreg(logic [2:0] sel, logic [7:0] wd);
        cyc(1, sel, wd, 0, 0, 0, 0, plane4);
    endtask

    task automatic rd(logic [2:0] sel, logic [7:0] exp_v, string tag);
        reg_sel = sel; #1;
        check(tag, 32'(reg_rdata), 32'(exp_v));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst = 1; reg_wr = 0; reg_sel = 0; reg_wdata = 0; plane4 = 1;
        active = 0; fetch_stb = 0; line_end = 0; frame_start = 0;
        m_ctr = '0; m_base = '0; m_ofs = '0; m_scr = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", 32'(fetch_addr), 32'h0);
        for (int s = 0; s < 8; s++) rd(3'(s), 8'h00, "R1");
        rst = 0;

        // R2 base bytes, alignment and high-byte width
        wreg(3'd5, 8'hFF);
        wreg(3'd4, 8'h12);
        wreg(3'd3, 8'h35);
        rd(3'd5, 8'h3F, "R2");
        rd(3'd4, 8'h12, "R2");
        rd(3'd3, 8'h34, "R2");

        // R3 frame reload
        cyc(0, 0, 0, 0, 0, 0, 1, 1);
        check("R3", 32'(fetch_addr), 32'h3F1234);

        // R4 fetch outside and inside the window
        cyc(0, 0, 0, 0, 1, 0, 0, 1);
        check("R4", 32'(fetch_addr), 32'h3F1234);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0, 0, 1);
        check("R4", 32'(fetch_addr), 32'h3F123A);

        // R10 zero offset, zero scroll
        cyc(0, 0, 0, 0, 0, 1, 0, 1);
        check("R10", 32'(fetch_addr), 32'h3F123A);

        // R5 plain offset
        wreg(3'd6, 8'd160);
        rd(3'd6, 8'd160, "R2");
        cyc(0, 0, 0, 0, 0, 1, 0, 1);
        check("R5", 32'(fetch_addr), 32'h3F137A);

        // R6 extra fetch with scroll, both plane modes
        wreg(3'd7, 8'hF5);
        rd(3'd7, 8'h05, "R2");
        wreg(3'd6, 8'd156);
        cyc(0, 0, 0, 0, 0, 1, 0, 1);
        check("R6", 32'(fetch_addr), 32'h3F14BA);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        check("R6", 32'(fetch_addr), 32'h3F15F4);

        // R7 counter readback and low-byte alignment
        cyc(1, 3'd0, 8'h57, 0, 0, 0, 0, 1);
        rd(3'd0, 8'h56, "R7");
        rd(3'd1, 8'h15, "R7");
        rd(3'd2, 8'h3F, "R7");

        // R8 host write against line end, frame start and fetch
        cyc(1, 3'd1, 8'hAB, 1, 1, 1, 0, 1);
        check("R8", 32'(fetch_addr), 32'h3FAB56);
        cyc(1, 3'd0, 8'h10, 1, 1, 0, 1, 1);
        check("R8", 32'(fetch_addr), 32'h3FAB10);

        // R9 frame over line end, line end over fetch
        cyc(0, 0, 0, 1, 1, 1, 1, 1);
        check("R9", 32'(fetch_addr), 32'h3F1234);
        cyc(0, 0, 0, 1, 1, 1, 0, 1);
        check("R9", 32'(fetch_addr), 32'h3F1374);

        // R11 wrap
        cyc(1, 3'd2, 8'h3F, 0, 0, 0, 0, 1);
        cyc(1, 3'd1, 8'hFF, 0, 0, 0, 0, 1);
        cyc(1, 3'd0, 8'hFF, 0, 0, 0, 0, 1);
        check("R11", 32'(fetch_addr), 32'h3FFFFE);
        cyc(0, 0, 0, 1, 1, 0, 0, 1);
        check("R11", 32'(fetch_addr), 32'h0);

        // random phase with frequent collisions
        for (int n = 0; n < 4000; n++) begin
            logic wr, act, fs, le, fr, p4;
            logic [2:0] sel;
            logic [7:0] wd;
            wr  = ($urandom % 6) == 0;
            sel = 3'($urandom);
            wd  = 8'($urandom);
            act = ($urandom % 4) != 0;
            fs  = ($urandom % 2) == 0;
            le  = ($urandom % 10) == 0;
            fr  = ($urandom % 40) == 0;
            p4  = (n / 500) % 2 == 0;
            if (wr && sel == 3'd7 && ($urandom % 2) == 0) wd = 8'h00;
            cyc(wr, sel, wd, act, fs, le, fr, p4);
            if ((n % 97) == 0) begin
                rd(3'd0, byte_of(m_ctr, 0), "R7");
                rd(3'd3, byte_of(m_base, 0), "R2");
                rd(3'd6, m_ofs, "R2");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule